// File: doc/BRIEF.md
# Buffered PWM Timebase Generator

This block is one edge-aligned PWM generator. A free-running timebase counter sets the cycle length. Compare logic against an active phase value and an active duty value produces the raw high-side output. The three timing values are never written to the active set directly. Software writes a holding copy, then raises an update request. The request comes either from an explicit strobe or from a write to one chosen holding register. The holding set is copied to the active set at a point fixed by the selected timing rule.

Two timing rules are offered. In start-of-cycle timing, a pending copy waits for the next cycle start. In immediate timing, the copy happens straight away while the current pulse is still in progress. The copy is held back to the next start once the pulse has ended, so no runt or second pulse appears. A cycle starts either by itself after enable and at every end of cycle, or from an external start strobe. An optional retrigger mode lets that strobe restart a running cycle. For lock-step updates across several generators, one generator can be made a host that forwards its request. Generators in client mode take that forwarded request instead of their own.

Top module: `pwmgen_core`

## Requirements
- R1: While running, the counter advances by one each clock and returns to 0 on the clock after it equals the active period, so a cycle lasts period+1 clocks. `eoc_pulse` is high for exactly the one clock after the counter equalled the active period.
- R2: `pwm_h` is registered. One clock after the counter holds value c, `pwm_h` is 1 exactly when phase <= c < duty, using the active values. The output therefore rises one clock after the counter equals phase and falls one clock after it equals duty.
- R3: Holding registers are written when `wr_en` is high, with `wr_sel` 0 = phase, 1 = duty, 2 = period and 3 = none. A write alone leaves the active values unchanged. A request is raised by `upd_req`, or by a write whose `wr_sel` equals `auto_sel`, where `auto_sel` = 3 disables this path.
- R4: With `imm_mode` = 0, a pending request copies all three holding values into the active set on the clock edge where a cycle starts.
- R5: With `imm_mode` = 1, a pending request is applied at once while the counter is below the active duty. A larger duty therefore extends the running pulse without a gap.
- R6: With `imm_mode` = 1, a smaller duty applied while the pulse is high and already past the new value ends the pulse on the next clock. If the counter has already reached the active duty, the request stays pending until the next cycle start.
- R7: An immediate period increase lengthens the running cycle. An immediate period decrease below the current count lets the counter run to its maximum, wrap and count up to the new period within the same cycle.
- R8: With `ext_mode` = 0, the first cycle starts on the edge where `en` is sampled high while idle, and each end of cycle starts the next. `soc_pulse` is high for one clock, in the clock when the counter shows 0.
- R9: With `ext_mode` = 1, a cycle starts only on `ext_soc`. While a cycle runs and has not reached its end, `ext_soc` is ignored unless `retrig_en` = 1, in which case it restarts the counter at 0.
- R10: With `host_en` = 1, every local request is echoed on `upd_bcast` one clock later. With `client_en` = 1, local requests are ignored and `host_upd_in` is the only request source.
- R11: `upd_pending` goes high the clock after an effective request. It clears on the edge where the copy happens, unless a new request arrives on that same edge.
- R12: Synchronous reset clears the counter, the outputs and the pending flag, and loads phase = duty = 0 and period = RST_PERIOD. With `en` low, the counter is held at 0 and `pwm_h`, `soc_pulse` and `eoc_pulse` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Generator enable |
| wr_en | input | 1 | Holding register write strobe |
| wr_sel | input | 2 | Holding register select (0 phase, 1 duty, 2 period, 3 none) |
| wr_data | input | W | Write data |
| upd_req | input | 1 | Explicit update request strobe |
| auto_sel | input | 2 | Register whose write raises a request (3 = none) |
| imm_mode | input | 1 | 0 = apply at cycle start, 1 = immediate |
| ext_mode | input | 1 | 0 = self-trigger, 1 = external start strobe |
| ext_soc | input | 1 | External start strobe |
| retrig_en | input | 1 | Allow external strobe to restart a running cycle |
| host_en | input | 1 | Forward local requests on upd_bcast |
| client_en | input | 1 | Take requests only from host_upd_in |
| host_upd_in | input | 1 | Request forwarded from a host generator |
| pwm_h | output | 1 | Raw high-side PWM output |
| soc_pulse | output | 1 | One-clock start-of-cycle pulse |
| eoc_pulse | output | 1 | One-clock end-of-cycle pulse |
| upd_pending | output | 1 | A request waits for its copy |
| upd_bcast | output | 1 | Forwarded request for client generators |

## Verification
The hardest state to reach is an immediate period decrease that lands below the live count while the pulse is still active. Only there does the counter take the wrap path, and the write must fall in a narrow window: after the new period value but before the active duty. The stimulus runs a long duty with a mid-length period, waits a counted number of clocks after a start pulse, and then writes the short period with the period write selected as the request source. It expects one cycle of 256 + 21 clocks. The deferred immediate update is reached the same way, by writing after the count has passed the duty and watching the pending flag stay high until the next start.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;
  // holding register selector; 3 means "no register"
  localparam logic [1:0] SEL_PHASE  = 2'd0;
  localparam logic [1:0] SEL_DUTY   = 2'd1;
  localparam logic [1:0] SEL_PERIOD = 2'd2;
  localparam logic [1:0] SEL_NONE   = 2'd3;
  localparam int         NUM_REGS   = 3;
endpackage

// File: rtl/pwmgen_timebase.sv
module pwmgen_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         ext_mode,
  input  logic         ext_soc,
  input  logic         retrig_en,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         running,
  output logic         start,
  output logic         eoc_now,
  output logic         soc_q,
  output logic         eoc_q
);
  logic trig_ok;
  logic may_start;

  always_comb begin
    eoc_now   = running && (cnt == period);
    trig_ok   = ext_mode ? ext_soc : 1'b1;
    may_start = !running || eoc_now || (retrig_en && ext_mode);
    start     = en && trig_ok && may_start;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
      soc_q   <= 1'b0;
      eoc_q   <= 1'b0;
    end else begin
      soc_q <= start;
      eoc_q <= en && eoc_now;
      if (!en) begin
        cnt     <= '0;
        running <= 1'b0;
      end else if (start) begin
        cnt     <= '0;
        running <= 1'b1;
      end else if (eoc_now) begin
        cnt     <= '0;
        running <= 1'b0;
      end else if (running) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwmgen_shadow.sv
module pwmgen_shadow
  import pwmgen_pkg::*;
#(
  parameter int W          = 16,
  parameter int RST_PERIOD = 255
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         upd_req,
  input  logic [1:0]   auto_sel,
  input  logic         imm_mode,
  input  logic         host_en,
  input  logic         client_en,
  input  logic         host_upd_in,
  input  logic         start,
  input  logic         running,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] act_phase,
  output logic [W-1:0] act_duty,
  output logic [W-1:0] act_period,
  output logic         local_req,
  output logic         pend,
  output logic         bcast_q
);
  localparam logic [W-1:0] PER_INIT = W'(RST_PERIOD);

  logic [W-1:0] hold_r [NUM_REGS];
  logic [W-1:0] act_r  [NUM_REGS];
  logic         eff_req;
  logic         pulse_done;
  logic         apply;

  always_comb begin
    local_req  = upd_req || (wr_en && (auto_sel != SEL_NONE) && (wr_sel == auto_sel));
    eff_req    = client_en ? host_upd_in : local_req;
    pulse_done = cnt >= act_r[SEL_DUTY];
    if (imm_mode) apply = pend && (start || !running || !pulse_done);
    else          apply = pend && start;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [W-1:0] INIT = (g == int'(SEL_PERIOD)) ? PER_INIT : '0;
    always_ff @(posedge clk) begin
      if (rst) begin
        hold_r[g] <= INIT;
        act_r[g]  <= INIT;
      end else begin
        if (wr_en && (wr_sel == 2'(g))) hold_r[g] <= wr_data;
        if (apply) act_r[g] <= hold_r[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      bcast_q <= 1'b0;
    end else begin
      bcast_q <= host_en && local_req;
      if (eff_req)    pend <= 1'b1;
      else if (apply) pend <= 1'b0;
    end
  end

  assign act_phase  = act_r[SEL_PHASE];
  assign act_duty   = act_r[SEL_DUTY];
  assign act_period = act_r[SEL_PERIOD];
endmodule

// File: rtl/pwmgen_compare.sv
module pwmgen_compare #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         running,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] phase,
  input  logic [W-1:0] duty,
  output logic         pwm_q
);
  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= en && running && (cnt >= phase) && (cnt < duty);
  end
endmodule

// File: rtl/pwmgen_core.sv
module pwmgen_core #(
  parameter int W          = 16,
  parameter int RST_PERIOD = 255
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         upd_req,
  input  logic [1:0]   auto_sel,
  input  logic         imm_mode,
  input  logic         ext_mode,
  input  logic         ext_soc,
  input  logic         retrig_en,
  input  logic         host_en,
  input  logic         client_en,
  input  logic         host_upd_in,
  output logic         pwm_h,
  output logic         soc_pulse,
  output logic         eoc_pulse,
  output logic         upd_pending,
  output logic         upd_bcast
);
  logic [W-1:0] cnt_w;
  logic         run_w;
  logic         start_w;
  logic         eoc_w;
  logic         lreq_w;
  logic [W-1:0] ph_w;
  logic [W-1:0] du_w;
  logic [W-1:0] pe_w;

  pwmgen_timebase #(.W(W)) u_tb (
    .clk(clk), .rst(rst), .en(en), .ext_mode(ext_mode), .ext_soc(ext_soc),
    .retrig_en(retrig_en), .period(pe_w), .cnt(cnt_w), .running(run_w),
    .start(start_w), .eoc_now(eoc_w), .soc_q(soc_pulse), .eoc_q(eoc_pulse)
  );

  pwmgen_shadow #(.W(W), .RST_PERIOD(RST_PERIOD)) u_sh (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .upd_req(upd_req), .auto_sel(auto_sel), .imm_mode(imm_mode),
    .host_en(host_en), .client_en(client_en), .host_upd_in(host_upd_in),
    .start(start_w), .running(run_w), .cnt(cnt_w),
    .act_phase(ph_w), .act_duty(du_w), .act_period(pe_w),
    .local_req(lreq_w), .pend(upd_pending), .bcast_q(upd_bcast)
  );

  pwmgen_compare #(.W(W)) u_cmp (
    .clk(clk), .rst(rst), .en(en), .running(run_w), .cnt(cnt_w),
    .phase(ph_w), .duty(du_w), .pwm_q(pwm_h)
  );
endmodule

// File: rtl/pwmgen_core_chk.sv
module pwmgen_core_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         ext_mode,
  input logic         retrig_en,
  input logic         client_en,
  input logic         host_upd_in,
  input logic         lreq,
  input logic [W-1:0] cnt,
  input logic         running,
  input logic         start,
  input logic         eoc_now,
  input logic [W-1:0] period,
  input logic         pwm_h,
  input logic         soc_pulse,
  input logic         eoc_pulse,
  input logic         upd_pending
);
  // R1: counter steps by one inside a cycle
  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    (en && running && !start && !eoc_now) |=> (cnt == W'($past(cnt) + 1'b1)));

  // R1: end pulse follows a period match
  p_eoc_match_r1: assert property (@(posedge clk) disable iff (rst)
    eoc_pulse |-> ($past(running) && ($past(cnt) == $past(period))));

  // R12: disabled generator produces no output
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (!pwm_h && !soc_pulse && !eoc_pulse));

  // R8: start pulse coincides with counter at zero
  p_soc_zero_r8: assert property (@(posedge clk) disable iff (rst)
    soc_pulse |-> (running && cnt == '0));

  // R9: external strobe ignored mid-cycle without retrigger
  p_no_retrig_r9: assert property (@(posedge clk) disable iff (rst)
    (ext_mode && !retrig_en && running && !eoc_now) |=> !soc_pulse);

  // R10: client ignores local requests
  p_client_local_r10: assert property (@(posedge clk) disable iff (rst)
    (client_en && !host_upd_in && !upd_pending) |=> !upd_pending);

  // R11: pending only rises after an effective request
  p_pend_cause_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(upd_pending) |-> $past(client_en ? host_upd_in : lreq));
endmodule

bind pwmgen_core pwmgen_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .ext_mode(ext_mode), .retrig_en(retrig_en),
  .client_en(client_en), .host_upd_in(host_upd_in), .lreq(lreq_w),
  .cnt(cnt_w), .running(run_w), .start(start_w), .eoc_now(eoc_w),
  .period(pe_w), .pwm_h(pwm_h), .soc_pulse(soc_pulse), .eoc_pulse(eoc_pulse),
  .upd_pending(upd_pending)
);

// File: tb/pwmgen_core_tb.sv
module pwmgen_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int RSTP = 15;
  localparam int MAXC = 1 << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 0, wr_en = 0, upd_req = 0, imm_mode = 0, ext_mode = 0, ext_soc = 0;
  logic retrig_en = 0, host_en = 0, client_en = 0, host_upd_in = 0;
  logic [1:0] wr_sel = 2'd3, auto_sel = 2'd3;
  logic [W-1:0] wr_data = '0;
  logic pwm_h, soc_pulse, eoc_pulse, upd_pending, upd_bcast;

  int n_checks = 0, n_fail = 0;
  int hi_cnt = 0, cyc_cnt = 0, soc_cnt = 0;
  bit done = 0;

  // reference model state
  int m_cnt, m_run, m_ph, m_du, m_pe, h_ph, h_du, h_pe;
  bit m_pend, m_h, m_soc, m_eoc, m_bc;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwmgen_core #(.W(W), .RST_PERIOD(RSTP)) u_dut (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .upd_req(upd_req), .auto_sel(auto_sel), .imm_mode(imm_mode), .ext_mode(ext_mode),
    .ext_soc(ext_soc), .retrig_en(retrig_en), .host_en(host_en), .client_en(client_en),
    .host_upd_in(host_upd_in), .pwm_h(pwm_h), .soc_pulse(soc_pulse), .eoc_pulse(eoc_pulse),
    .upd_pending(upd_pending), .upd_bcast(upd_bcast)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit lreq, ereq, eoc, trig, st, pdone, app;
    if (rst) begin
      m_cnt = 0; m_run = 0; m_ph = 0; m_du = 0; m_pe = RSTP;
      h_ph = 0; h_du = 0; h_pe = RSTP;
      m_pend = 0; m_h = 0; m_soc = 0; m_eoc = 0; m_bc = 0;
      return;
    end
    lreq  = upd_req || (wr_en && auto_sel != 3 && wr_sel == auto_sel);
    ereq  = client_en ? host_upd_in : lreq;
    eoc   = m_run && (m_cnt == m_pe);
    trig  = ext_mode ? ext_soc : 1'b1;
    st    = en && trig && (!m_run || eoc || (retrig_en && ext_mode));
    pdone = m_cnt >= m_du;
    app   = m_pend && (imm_mode ? (st || !m_run || !pdone) : st);
    m_h   = en && m_run && (m_cnt >= m_ph) && (m_cnt < m_du);
    m_soc = st;
    m_eoc = en && eoc;
    m_bc  = host_en && lreq;
    if (app) begin m_ph = h_ph; m_du = h_du; m_pe = h_pe; end
    if (wr_en) begin
      if (wr_sel == 0) h_ph = wr_data;
      else if (wr_sel == 1) h_du = wr_data;
      else if (wr_sel == 2) h_pe = wr_data;
    end
    if (ereq) m_pend = 1; else if (app) m_pend = 0;
    if (!en) begin m_cnt = 0; m_run = 0; end
    else if (st) begin m_cnt = 0; m_run = 1; end
    else if (eoc) begin m_cnt = 0; m_run = 0; end
    else if (m_run) m_cnt = (m_cnt + 1) % MAXC;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    #1;
    cyc_cnt++;
    if (pwm_h) hi_cnt++;
    if (soc_pulse) soc_cnt++;
    check(pwm_h == m_h, "R2 pwm_h", pwm_h, m_h);
    check(soc_pulse == m_soc, "R8 soc_pulse", soc_pulse, m_soc);
    check(eoc_pulse == m_eoc, "R1 eoc_pulse", eoc_pulse, m_eoc);
    check(upd_pending == m_pend, "R11 upd_pending", upd_pending, m_pend);
    check(upd_bcast == m_bc, "R10 upd_bcast", upd_bcast, m_bc);
  endtask

  task automatic wr(input logic [1:0] s, input int d);
    wr_en = 1; wr_sel = s; wr_data = W'(d);
    cyc();
    wr_en = 0; wr_sel = 2'd3;
  endtask

  task automatic req();
    upd_req = 1; cyc(); upd_req = 0;
  endtask

  task automatic wait_soc();
    do cyc(); while (!soc_pulse);
  endtask

  task automatic clr();
    hi_cnt = 0; cyc_cnt = 0; soc_cnt = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst = 0;
    // R12 reset state
    check(!pwm_h && !soc_pulse && !eoc_pulse && !upd_pending, "R12 reset outputs", pwm_h, 0);

    // R3: writes without request leave reset values in force
    wr(0, 2); wr(1, 6); wr(2, 9);
    en = 1;
    wait_soc(); clr(); wait_soc();
    check(cyc_cnt == RSTP + 1, "R3 period unchanged", cyc_cnt, RSTP + 1);
    check(hi_cnt == 0, "R3 duty unchanged", hi_cnt, 0);

    // R4 start-of-cycle apply, R1 length, R2 width
    req();
    wait_soc(); clr(); wait_soc();
    check(cyc_cnt == 10, "R1 cycle length", cyc_cnt, 10);
    check(hi_cnt == 4, "R2 high width", hi_cnt, 4);
    check(soc_cnt == 1, "R4 one start per cycle", soc_cnt, 1);

    // R12 disable, R8 restart on enable
    en = 0; repeat (4) cyc();
    check(!pwm_h && !soc_pulse, "R12 disabled quiet", pwm_h, 0);
    en = 1; cyc();
    check(soc_pulse == 1, "R8 first start after enable", soc_pulse, 1);

    // R5 immediate extension
    imm_mode = 1; auto_sel = 2'd1;
    wr(0, 0); wr(2, 19); wr(1, 5);
    wait_soc(); wait_soc();
    clr(); cyc(); wr(1, 12);
    do cyc(); while (!soc_pulse);
    check(hi_cnt == 12, "R5 extended pulse", hi_cnt, 12);

    // R6 immediate truncation
    clr(); repeat (6) cyc(); wr(1, 3);
    do cyc(); while (!soc_pulse);
    check(hi_cnt == 8, "R6 truncated pulse", hi_cnt, 8);

    // R6 deferral after pulse end, R11 pending held then cleared
    clr(); repeat (10) cyc(); wr(1, 9); cyc(); cyc();
    check(upd_pending == 1, "R11 deferred pending", upd_pending, 1);
    do cyc(); while (!soc_pulse);
    check(hi_cnt == 3, "R6 no second pulse", hi_cnt, 3);
    check(upd_pending == 0, "R11 pending cleared", upd_pending, 0);
    clr(); do cyc(); while (!soc_pulse);
    check(hi_cnt == 9, "R6 deferred duty applied", hi_cnt, 9);

    // R7 immediate period lengthen
    auto_sel = 2'd2;
    clr(); repeat (5) cyc(); wr(2, 39);
    do cyc(); while (!soc_pulse);
    check(cyc_cnt == 40, "R7 lengthened cycle", cyc_cnt, 40);

    // R7 immediate period shorten below count: wrap
    auto_sel = 2'd3; wr(1, 200); auto_sel = 2'd2; wr(2, 100);
    wait_soc(); wait_soc();
    clr(); repeat (50) cyc(); wr(2, 20);
    do cyc(); while (!soc_pulse);
    check(cyc_cnt == MAXC + 21, "R7 rollover cycle", cyc_cnt, MAXC + 21);

    // R9 external trigger and retrigger
    imm_mode = 0; auto_sel = 2'd3;
    wr(1, 4); wr(2, 9); req();
    wait_soc(); wait_soc();
    ext_mode = 1; repeat (25) cyc();
    clr(); repeat (10) cyc();
    check(soc_cnt == 0, "R9 idle without strobe", soc_cnt, 0);
    ext_soc = 1; cyc(); ext_soc = 0;
    check(soc_pulse == 1, "R9 strobe starts cycle", soc_pulse, 1);
    repeat (3) cyc();
    ext_soc = 1; cyc(); ext_soc = 0;
    check(soc_pulse == 0, "R9 strobe ignored mid-cycle", soc_pulse, 0);
    retrig_en = 1; cyc();
    ext_soc = 1; cyc(); ext_soc = 0;
    check(soc_pulse == 1, "R9 retrigger restarts", soc_pulse, 1);
    repeat (15) cyc();

    // R10 host broadcast and client source
    host_en = 1; req();
    check(upd_bcast == 1, "R10 host forwards request", upd_bcast, 1);
    host_en = 0; repeat (2) cyc();
    check(upd_pending == 1, "R11 pending while idle", upd_pending, 1);
    ext_soc = 1; cyc(); ext_soc = 0; cyc();
    check(upd_pending == 0, "R11 cleared at start", upd_pending, 0);
    repeat (15) cyc();
    client_en = 1; req(); cyc();
    check(upd_pending == 0, "R10 client ignores local", upd_pending, 0);
    host_upd_in = 1; cyc(); host_upd_in = 0;
    check(upd_pending == 1, "R10 client takes host request", upd_pending, 1);
    repeat (5) cyc();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule